// File: doc/BRIEF.md
# Stallable Pipeline Stage with Skid Buffer

This block is one front-end pipeline stage. Each cycle it accepts up to `IN_W` instruction slots from the stage above and hands up to `OUT_W` slots to the stage below. Each slot carries a valid bit, a killed flag, a sequence number and an opaque payload. The block does no decoding. It manages flow. It tracks stall requests from three downstream stages. While it is stalled it parks arriving work in a skid buffer, and it empties that buffer, oldest entry first, before normal flow resumes. It tells the stage above when to stop and when to restart with single-cycle pulses that are sent only when its status changes. A squash request from the last stage clears everything it holds.

All outputs are registered. A decision made on one clock edge shows up on the outputs right after that edge. The skid buffer holds `IN_LAT*IN_W + OUT_W` entries. This covers the slots still in flight from the stage above after it has been told to stop, plus one output row.

Top module: `stall_skid_stage`

## Requirements
- R1: After reset, `stageState` is Idle and `outValid`, `upBlock`, `upUnblock`, `activity` and `skidOverflow` are all 0. The state encoding is Idle=0, Running=1, Blocked=2, Unblocking=3, Squashing=4. Reset also clears all downstream stall flags.
- R2: Each downstream index i has a stall flag. A pulse on `dnBlock[i]` sets the flag and a pulse on `dnUnblock[i]` clears it. If both pulse in the same cycle, the flag ends up clear. The stage is stalled in any cycle where, after that cycle's pulses are applied, at least one flag is set.
- R3: In Running or Idle, the live slots (valid and not killed) are forwarded in their input order, compacted into output slot 0 upward, at most `OUT_W` per cycle. Killed slots are discarded and take up no output slot.
- R4: In Running or Idle, live slots beyond `OUT_W` go into the skid buffer. In that case `upBlock` pulses and the state becomes Blocked.
- R5: When the stage is stalled, all live input goes into the skid buffer, nothing is output and the state becomes Blocked. `upBlock` pulses only if the state was neither Blocked nor Unblocking.
- R6: Once the stall has cleared while the state is Blocked or Unblocking, the output is filled from the skid buffer, oldest entry first, and new live input is appended behind it. If the buffer is empty after that cycle, `upUnblock` pulses and the state becomes Running. Otherwise the state is Unblocking.
- R7: `squashReq` clears the skid buffer, discards the input, sends nothing downstream and sets the state to Squashing. `upUnblock` pulses only if the state was Blocked or Unblocking. `upBlock` never pulses in a squash cycle and never pulses together with `upUnblock`.
- R8: `squashHold` without `squashReq` sets the state to Squashing, discards the input and sends nothing downstream.
- R9: The order of precedence is fixed: squash request first, then hold, then stall, then leaving Blocked or Unblocking, then normal flow.
- R10: From Squashing, the first cycle with no squash, hold or stall returns the state to Running and forwards that cycle's input.
- R11: The skid buffer holds `IN_LAT*IN_W + OUT_W` entries (5 with the default parameters). Live slots that do not fit are dropped, and `skidOverflow` pulses in the following cycle.
- R12: `activity` is 1 exactly in the cycles where some output slot is valid or an upstream pulse is being sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | IN_W | Valid bit of each input slot |
| inKill | input | IN_W | Killed flag of each input slot |
| inSeq | input | IN_W*SEQ_W | Sequence numbers, slot i at bits i*SEQ_W |
| inData | input | IN_W*PAY_W | Payloads, slot i at bits i*PAY_W |
| dnBlock | input | NUM_DOWN | Stall-set pulse from each downstream stage |
| dnUnblock | input | NUM_DOWN | Stall-clear pulse from each downstream stage |
| squashReq | input | 1 | Flush request from the final stage |
| squashHold | input | 1 | Final stage is still flushing |
| outValid | output | OUT_W | Valid bit of each output slot |
| outSeq | output | OUT_W*SEQ_W | Output sequence numbers |
| outData | output | OUT_W*PAY_W | Output payloads |
| upBlock | output | 1 | One-cycle stop request to the stage above |
| upUnblock | output | 1 | One-cycle restart notice to the stage above |
| stageState | output | 3 | Current state, encoded as in R1 |
| activity | output | 1 | Work or handshake this cycle |
| skidOverflow | output | 1 | A live slot was dropped for lack of room |

## Verification
The assertions check the properties that must hold in every cycle. The two upstream pulses never occur together. Output slots always form a contiguous run starting at slot 0. Each pulse agrees with the state it leaves behind. A squash or a hold always lands the stage in Squashing with no output. An overflow happens only while the stage is parking or draining. The bench scenarios cover what only a sequence of cycles can show: the actual sequence numbers that come out, oldest-first draining across several cycles, which entries are lost on overflow, the precedence between a squash, a hold and a stall that is still pending, and the way flags set and cleared by separate pulses combine over time.

// File: rtl/stall_skid_pkg.sv
package stall_skid_pkg;

  typedef enum logic [2:0] {
    ST_IDLE       = 3'd0,
    ST_RUN        = 3'd1,
    ST_BLOCKED    = 3'd2,
    ST_UNBLOCKING = 3'd3,
    ST_SQUASHING  = 3'd4
  } stage_state_e;

  // Strobes from control to datapath; at most one is set per cycle.
  typedef struct packed {
    logic flush;  // empty the skid buffer, drop input
    logic park;   // push every live input slot into the skid buffer
    logic pass;   // forward live input, overflow beyond OUT_W into skid
    logic drain;  // forward from skid head, append live input behind
  } dp_cmd_t;

endpackage

// File: rtl/stall_skid_ctrl.sv
module stall_skid_ctrl
  import stall_skid_pkg::*;
#(
  parameter int OUT_W    = 2,
  parameter int NUM_DOWN = 3,
  parameter int LIVE_W   = 2,
  parameter int LVL_W    = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_DOWN-1:0] dnBlock,
  input  logic [NUM_DOWN-1:0] dnUnblock,
  input  logic                squashReq,
  input  logic                squashHold,
  input  logic [LIVE_W-1:0]   liveCount,
  input  logic [LVL_W-1:0]    skidCount,
  output dp_cmd_t             cmd,
  output stage_state_e        stateQ,
  output logic                upBlockQ,
  output logic                upUnblockQ
);

  logic [NUM_DOWN-1:0] flagsQ, flagsD;
  stage_state_e        stateD;
  logic                stalled, blockedLike, drainEmpties;
  logic                upBlockD, upUnblockD;

  always_comb begin
    // unblock wins over block in the same cycle
    flagsD       = (flagsQ | dnBlock) & ~dnUnblock;
    stalled      = |flagsD;
    blockedLike  = (stateQ == ST_BLOCKED) || (stateQ == ST_UNBLOCKING);
    drainEmpties = (int'(skidCount) <= OUT_W) && (liveCount == '0);

    cmd        = '0;
    stateD     = stateQ;
    upBlockD   = 1'b0;
    upUnblockD = 1'b0;

    if (squashReq) begin
      cmd.flush  = 1'b1;
      stateD     = ST_SQUASHING;
      upUnblockD = blockedLike;
    end else if (squashHold) begin
      stateD = ST_SQUASHING;
    end else if (stalled) begin
      cmd.park = 1'b1;
      stateD   = ST_BLOCKED;
      upBlockD = !blockedLike;
    end else if (blockedLike) begin
      cmd.drain = 1'b1;
      if (drainEmpties) begin
        upUnblockD = 1'b1;
        stateD     = ST_RUN;
      end else begin
        stateD = ST_UNBLOCKING;
      end
    end else begin
      // Idle, Running, or leaving Squashing
      cmd.pass = 1'b1;
      if (int'(liveCount) > OUT_W) begin
        upBlockD = 1'b1;
        stateD   = ST_BLOCKED;
      end else if (stateQ == ST_IDLE && liveCount == '0) begin
        stateD = ST_IDLE;
      end else begin
        stateD = ST_RUN;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagsQ     <= '0;
      stateQ     <= ST_IDLE;
      upBlockQ   <= 1'b0;
      upUnblockQ <= 1'b0;
    end else begin
      flagsQ     <= flagsD;
      stateQ     <= stateD;
      upBlockQ   <= upBlockD;
      upUnblockQ <= upUnblockD;
    end
  end

endmodule

// File: rtl/stall_skid_datapath.sv
module stall_skid_datapath
  import stall_skid_pkg::*;
#(
  parameter int IN_W   = 3,
  parameter int OUT_W  = 2,
  parameter int DEPTH  = 5,
  parameter int SEQ_W  = 8,
  parameter int PAY_W  = 8,
  parameter int LIVE_W = 2,
  parameter int LVL_W  = 3
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  dp_cmd_t                  cmd,
  input  logic [IN_W-1:0]          inValid,
  input  logic [IN_W-1:0]          inKill,
  input  logic [IN_W*SEQ_W-1:0]    inSeq,
  input  logic [IN_W*PAY_W-1:0]    inData,
  output logic [LIVE_W-1:0]        liveCount,
  output logic [LVL_W-1:0]         skidCount,
  output logic [OUT_W-1:0]         outValidQ,
  output logic [OUT_W*SEQ_W-1:0]   outSeqQ,
  output logic [OUT_W*PAY_W-1:0]   outDataQ,
  output logic                     overflowQ
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [SEQ_W-1:0] memSeq  [DEPTH];
  logic [PAY_W-1:0] memData [DEPTH];
  logic [PTR_W-1:0] headQ, headD;
  logic [LVL_W-1:0] cntQ, cntD;

  logic [SEQ_W-1:0] cSeq  [IN_W];
  logic [PAY_W-1:0] cData [IN_W];
  logic [IN_W-1:0]  wrEn;
  logic [PTR_W-1:0] wrAddr [IN_W];

  logic [OUT_W-1:0]       nxtValid;
  logic [OUT_W*SEQ_W-1:0] nxtSeq;
  logic [OUT_W*PAY_W-1:0] nxtData;
  logic                   overflowD;

  int liveN, popN, pushBase, req, acc;

  function automatic logic [PTR_W-1:0] wrapIdx(input int v);
    return PTR_W'(v % DEPTH);
  endfunction

  // Compact live slots to the front, keeping input order.
  always_comb begin
    liveN = 0;
    for (int i = 0; i < IN_W; i++) begin
      cSeq[i]  = '0;
      cData[i] = '0;
    end
    for (int i = 0; i < IN_W; i++) begin
      if (inValid[i] && !inKill[i]) begin
        cSeq[liveN]  = inSeq[i*SEQ_W +: SEQ_W];
        cData[liveN] = inData[i*PAY_W +: PAY_W];
        liveN++;
      end
    end
  end

  assign liveCount = LIVE_W'(liveN);
  assign skidCount = cntQ;

  // Output row selection and skid writes.
  always_comb begin
    popN = 0;
    if (cmd.drain) popN = (int'(cntQ) > OUT_W) ? OUT_W : int'(cntQ);

    nxtValid = '0;
    nxtSeq   = '0;
    nxtData  = '0;
    for (int k = 0; k < OUT_W; k++) begin
      if (cmd.pass && k < liveN) begin
        nxtValid[k]              = 1'b1;
        nxtSeq[k*SEQ_W +: SEQ_W] = cSeq[k];
        nxtData[k*PAY_W +: PAY_W] = cData[k];
      end else if (cmd.drain && k < popN) begin
        nxtValid[k]              = 1'b1;
        nxtSeq[k*SEQ_W +: SEQ_W] = memSeq[wrapIdx(int'(headQ) + k)];
        nxtData[k*PAY_W +: PAY_W] = memData[wrapIdx(int'(headQ) + k)];
      end
    end

    pushBase = cmd.pass ? OUT_W : 0;
    req = 0;
    acc = 0;
    for (int j = 0; j < IN_W; j++) begin
      wrEn[j]   = 1'b0;
      wrAddr[j] = '0;
      if ((cmd.pass || cmd.park || cmd.drain) && j >= pushBase && j < liveN) begin
        req++;
        if (int'(cntQ) - popN + acc < DEPTH) begin
          wrEn[j]   = 1'b1;
          wrAddr[j] = wrapIdx(int'(headQ) + int'(cntQ) + acc);
          acc++;
        end
      end
    end
    overflowD = (req > acc);

    if (cmd.flush) begin
      headD = '0;
      cntD  = '0;
    end else begin
      headD = wrapIdx(int'(headQ) + popN);
      cntD  = LVL_W'(int'(cntQ) - popN + acc);
    end
  end

  always_ff @(posedge clk) begin
    for (int j = 0; j < IN_W; j++) begin
      if (wrEn[j]) begin
        memSeq[wrAddr[j]]  <= cSeq[j];
        memData[wrAddr[j]] <= cData[j];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      headQ     <= '0;
      cntQ      <= '0;
      outValidQ <= '0;
      outSeqQ   <= '0;
      outDataQ  <= '0;
      overflowQ <= 1'b0;
    end else begin
      headQ     <= headD;
      cntQ      <= cntD;
      outValidQ <= nxtValid;
      outSeqQ   <= nxtSeq;
      outDataQ  <= nxtData;
      overflowQ <= overflowD;
    end
  end

endmodule

// File: rtl/stall_skid_stage.sv
module stall_skid_stage
  import stall_skid_pkg::*;
#(
  parameter int IN_W     = 3,
  parameter int OUT_W    = 2,
  parameter int IN_LAT   = 1,
  parameter int NUM_DOWN = 3,
  parameter int SEQ_W    = 8,
  parameter int PAY_W    = 8
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [IN_W-1:0]        inValid,
  input  logic [IN_W-1:0]        inKill,
  input  logic [IN_W*SEQ_W-1:0]  inSeq,
  input  logic [IN_W*PAY_W-1:0]  inData,
  input  logic [NUM_DOWN-1:0]    dnBlock,
  input  logic [NUM_DOWN-1:0]    dnUnblock,
  input  logic                   squashReq,
  input  logic                   squashHold,
  output logic [OUT_W-1:0]       outValid,
  output logic [OUT_W*SEQ_W-1:0] outSeq,
  output logic [OUT_W*PAY_W-1:0] outData,
  output logic                   upBlock,
  output logic                   upUnblock,
  output logic [2:0]             stageState,
  output logic                   activity,
  output logic                   skidOverflow
);

  localparam int DEPTH  = IN_LAT * IN_W + OUT_W;
  localparam int LIVE_W = $clog2(IN_W + 1);
  localparam int LVL_W  = $clog2(DEPTH + 1);

  dp_cmd_t          cmd;
  stage_state_e     stateQ;
  logic [LIVE_W-1:0] liveCount;
  logic [LVL_W-1:0]  skidCount;

  stall_skid_ctrl #(
    .OUT_W(OUT_W), .NUM_DOWN(NUM_DOWN), .LIVE_W(LIVE_W), .LVL_W(LVL_W)
  ) ctrl_i (
    .clk(clk), .rstN(rstN),
    .dnBlock(dnBlock), .dnUnblock(dnUnblock),
    .squashReq(squashReq), .squashHold(squashHold),
    .liveCount(liveCount), .skidCount(skidCount),
    .cmd(cmd), .stateQ(stateQ),
    .upBlockQ(upBlock), .upUnblockQ(upUnblock)
  );

  stall_skid_datapath #(
    .IN_W(IN_W), .OUT_W(OUT_W), .DEPTH(DEPTH), .SEQ_W(SEQ_W), .PAY_W(PAY_W),
    .LIVE_W(LIVE_W), .LVL_W(LVL_W)
  ) dp_i (
    .clk(clk), .rstN(rstN), .cmd(cmd),
    .inValid(inValid), .inKill(inKill), .inSeq(inSeq), .inData(inData),
    .liveCount(liveCount), .skidCount(skidCount),
    .outValidQ(outValid), .outSeqQ(outSeq), .outDataQ(outData),
    .overflowQ(skidOverflow)
  );

  assign stageState = stateQ;
  assign activity   = (|outValid) | upBlock | upUnblock;

endmodule

// File: rtl/stall_skid_checker.sv
module stall_skid_checker #(
  parameter int OUT_W = 2
) (
  input logic             clk,
  input logic             rstN,
  input logic             squashReq,
  input logic             squashHold,
  input logic [OUT_W-1:0] outValid,
  input logic             upBlock,
  input logic             upUnblock,
  input logic [2:0]       stageState,
  input logic             skidOverflow
);
  import stall_skid_pkg::*;

  AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(upBlock && upUnblock)); // R7

  AST_OUT_PACKED: assert property (@(posedge clk) disable iff (!rstN)
    (OUT_W'(outValid + OUT_W'(1)) & outValid) == '0); // R3

  AST_BLOCK_STATE: assert property (@(posedge clk) disable iff (!rstN)
    upBlock |-> stageState == ST_BLOCKED); // R5

  AST_UNBLOCK_STATE: assert property (@(posedge clk) disable iff (!rstN)
    upUnblock |-> (stageState == ST_RUN || stageState == ST_SQUASHING)); // R6

  AST_SQUASH_ENTRY: assert property (@(posedge clk) disable iff (!rstN)
    squashReq |=> (stageState == ST_SQUASHING && outValid == '0 && !upBlock)); // R7

  AST_HOLD_ENTRY: assert property (@(posedge clk) disable iff (!rstN)
    (squashHold && !squashReq) |=> (stageState == ST_SQUASHING && outValid == '0)); // R8

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    skidOverflow |-> (stageState == ST_BLOCKED || stageState == ST_UNBLOCKING)); // R11

endmodule

bind stall_skid_stage stall_skid_checker #(.OUT_W(OUT_W)) chk_i (
  .clk(clk), .rstN(rstN), .squashReq(squashReq), .squashHold(squashHold),
  .outValid(outValid), .upBlock(upBlock), .upUnblock(upUnblock),
  .stageState(stageState), .skidOverflow(skidOverflow)
);

// File: tb/stall_skid_stage_tb_top.sv
module stall_skid_stage_tb_top;

  localparam int IN_W = 3, OUT_W = 2, SEQ_W = 8, PAY_W = 8, NUM_DOWN = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [IN_W-1:0]        inValid = '0, inKill = '0;
  logic [IN_W*SEQ_W-1:0]  inSeq = '0;
  logic [IN_W*PAY_W-1:0]  inData = '0;
  logic [NUM_DOWN-1:0]    dnBlock = '0, dnUnblock = '0;
  logic                   squashReq = 1'b0, squashHold = 1'b0;
  logic [OUT_W-1:0]       outValid;
  logic [OUT_W*SEQ_W-1:0] outSeq;
  logic [OUT_W*PAY_W-1:0] outData;
  logic                   upBlock, upUnblock, activity, skidOverflow;
  logic [2:0]             stageState;

  int nChk = 0;
  int nErr = 0;

  always #2 clk = ~clk;

  stall_skid_stage dut_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inKill(inKill),
    .inSeq(inSeq), .inData(inData), .dnBlock(dnBlock), .dnUnblock(dnUnblock),
    .squashReq(squashReq), .squashHold(squashHold), .outValid(outValid),
    .outSeq(outSeq), .outData(outData), .upBlock(upBlock), .upUnblock(upUnblock),
    .stageState(stageState), .activity(activity), .skidOverflow(skidOverflow)
  );

  // vin, kill, base seq, dnBlock, dnUnblock, sq, hold | expected outValid,
  // seq slot0, seq slot1, upBlock, upUnblock, state
  typedef struct packed {
    logic [2:0] vin;  logic [2:0] kill; logic [7:0] base;
    logic [2:0] blk;  logic [2:0] unb;  logic sq; logic hold;
    logic [1:0] eV;   logic [7:0] e0;   logic [7:0] e1;
    logic eB; logic eU; logic [2:0] eS;
  } vec_t;

  localparam int NV = 18;
  localparam logic [44:0] TBL [NV] = '{
    {3'b000,3'b000,8'd0,  3'b000,3'b000,1'b0,1'b0, 2'b00,8'd0,  8'd0,  1'b0,1'b0,3'd0}, // R1 idle stays idle
    {3'b011,3'b000,8'd10, 3'b000,3'b000,1'b0,1'b0, 2'b11,8'd10, 8'd11, 1'b0,1'b0,3'd1}, // R3 pass two
    {3'b111,3'b010,8'd20, 3'b000,3'b000,1'b0,1'b0, 2'b11,8'd20, 8'd22, 1'b0,1'b0,3'd1}, // R3 killed slot dropped
    {3'b111,3'b000,8'd30, 3'b000,3'b000,1'b0,1'b0, 2'b11,8'd30, 8'd31, 1'b1,1'b0,3'd2}, // R4 leftover blocks
    {3'b011,3'b000,8'd40, 3'b000,3'b000,1'b0,1'b0, 2'b01,8'd32, 8'd0,  1'b0,1'b0,3'd3}, // R6 drain + append
    {3'b000,3'b000,8'd0,  3'b000,3'b000,1'b0,1'b0, 2'b11,8'd40, 8'd41, 1'b0,1'b1,3'd1}, // R6 emptied, unblock
    {3'b101,3'b000,8'd50, 3'b010,3'b000,1'b0,1'b0, 2'b00,8'd0,  8'd0,  1'b1,1'b0,3'd2}, // R5 R2 stall parks
    {3'b001,3'b000,8'd60, 3'b000,3'b000,1'b0,1'b0, 2'b00,8'd0,  8'd0,  1'b0,1'b0,3'd2}, // R5 R2 flag holds, no repeat block
    {3'b000,3'b000,8'd0,  3'b000,3'b010,1'b0,1'b0, 2'b11,8'd50, 8'd52, 1'b0,1'b0,3'd3}, // R6 R2 cleared, oldest first
    {3'b000,3'b000,8'd0,  3'b000,3'b000,1'b0,1'b0, 2'b01,8'd60, 8'd0,  1'b0,1'b1,3'd1}, // R6 last entry
    {3'b001,3'b000,8'd70, 3'b001,3'b001,1'b0,1'b0, 2'b01,8'd70, 8'd0,  1'b0,1'b0,3'd1}, // R2 unblock wins
    {3'b000,3'b000,8'd0,  3'b100,3'b000,1'b0,1'b0, 2'b00,8'd0,  8'd0,  1'b1,1'b0,3'd2}, // R5 stall, empty input
    {3'b011,3'b000,8'd80, 3'b000,3'b000,1'b1,1'b0, 2'b00,8'd0,  8'd0,  1'b0,1'b1,3'd4}, // R7 R9 squash over stall
    {3'b001,3'b000,8'd90, 3'b000,3'b000,1'b0,1'b1, 2'b00,8'd0,  8'd0,  1'b0,1'b0,3'd4}, // R8 R9 hold over stall
    {3'b001,3'b000,8'd91, 3'b000,3'b000,1'b0,1'b0, 2'b00,8'd0,  8'd0,  1'b1,1'b0,3'd2}, // R9 stall beats squash exit
    {3'b000,3'b000,8'd0,  3'b000,3'b100,1'b0,1'b0, 2'b01,8'd91, 8'd0,  1'b0,1'b1,3'd1}, // R6 drain single
    {3'b001,3'b000,8'd95, 3'b000,3'b000,1'b1,1'b0, 2'b00,8'd0,  8'd0,  1'b0,1'b0,3'd4}, // R7 no unblock from Running
    {3'b011,3'b000,8'd100,3'b000,3'b000,1'b0,1'b0, 2'b11,8'd100,8'd101,1'b0,1'b0,3'd1}  // R10 exit squash, forward
  };

  task automatic check(input string tag, input int act, input int exp);
    nChk++;
    if (act != exp) begin
      nErr++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [2:0] vin, input logic [2:0] kill,
                       input logic [7:0] base, input logic [2:0] blk,
                       input logic [2:0] unb, input logic sq, input logic hold);
    @(negedge clk);
    inValid = vin; inKill = kill; dnBlock = blk; dnUnblock = unb;
    squashReq = sq; squashHold = hold;
    for (int i = 0; i < IN_W; i++) begin
      inSeq[i*SEQ_W +: SEQ_W]  = base + 8'(i);
      inData[i*PAY_W +: PAY_W] = (base + 8'(i)) ^ 8'hA5;
    end
    @(posedge clk);
    #1;
  endtask

  task automatic checkSlot(input string tag, input int k, input int expSeq);
    check({tag, " seq"}, int'(outSeq[k*SEQ_W +: SEQ_W]), expSeq);
    check({tag, " data"}, int'(outData[k*PAY_W +: PAY_W]), int'(8'(expSeq) ^ 8'hA5));
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    inValid = '0; dnBlock = '0; dnUnblock = '0; squashReq = 1'b0; squashHold = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  initial begin
    #(200000 * 4);
    nErr++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nErr);
    $finish;
  end

  initial begin
    vec_t v;
    doReset();
    #1;
    // R1 reset state
    check("R1 state", int'(stageState), 0);
    check("R1 outValid", int'(outValid), 0);
    check("R1 pulses", int'({upBlock, upUnblock}), 0);
    check("R1 activity", int'(activity), 0);
    check("R1 overflow", int'(skidOverflow), 0);

    for (int n = 0; n < NV; n++) begin
      v = vec_t'(TBL[n]);
      drive(v.vin, v.kill, v.base, v.blk, v.unb, v.sq, v.hold);
      check($sformatf("R3 vec%0d outValid", n), int'(outValid), int'(v.eV));
      if (v.eV[0]) checkSlot($sformatf("R3 vec%0d slot0", n), 0, int'(v.e0));
      if (v.eV[1]) checkSlot($sformatf("R3 vec%0d slot1", n), 1, int'(v.e1));
      check($sformatf("R5 vec%0d upBlock", n), int'(upBlock), int'(v.eB));
      check($sformatf("R6 vec%0d upUnblock", n), int'(upUnblock), int'(v.eU));
      check($sformatf("R9 vec%0d state", n), int'(stageState), int'(v.eS));
      check($sformatf("R12 vec%0d activity", n), int'(activity),
            int'((v.eV != 2'b00) || v.eB || v.eU));
    end

    // R11 overflow: capacity 5, three parked, then three more of which one is dropped
    doReset();
    drive(3'b111, 3'b000, 8'h10, 3'b001, 3'b000, 1'b0, 1'b0);
    check("R11 no overflow at 3", int'(skidOverflow), 0);
    check("R5 block pulse", int'(upBlock), 1);
    drive(3'b111, 3'b000, 8'h20, 3'b000, 3'b000, 1'b0, 1'b0);
    check("R11 overflow flagged", int'(skidOverflow), 1);
    check("R12 quiet when parking", int'(activity), 0);
    drive(3'b000, 3'b000, 8'h00, 3'b000, 3'b001, 1'b0, 1'b0);
    check("R11 overflow clears", int'(skidOverflow), 0);
    check("R6 drain row a", int'(outValid), 3);
    checkSlot("R6 drain a0", 0, 8'h10);
    checkSlot("R6 drain a1", 1, 8'h11);
    drive(3'b000, 3'b000, 8'h00, 3'b000, 3'b000, 1'b0, 1'b0);
    checkSlot("R6 drain b0", 0, 8'h12);
    checkSlot("R6 drain b1", 1, 8'h20);
    check("R6 still unblocking", int'(stageState), 3);
    drive(3'b000, 3'b000, 8'h00, 3'b000, 3'b000, 1'b0, 1'b0);
    check("R11 only survivor left", int'(outValid), 1);
    checkSlot("R11 survivor", 0, 8'h21);
    check("R6 unblock after drain", int'(upUnblock), 1);
    drive(3'b000, 3'b000, 8'h00, 3'b000, 3'b000, 1'b0, 1'b0);
    check("R11 dropped entry absent", int'(outValid), 0);

    // R7 squash while Unblocking clears skid and sends unblock
    drive(3'b111, 3'b000, 8'h40, 3'b000, 3'b000, 1'b0, 1'b0);  // leftover 0x42 -> Blocked
    drive(3'b111, 3'b000, 8'h50, 3'b000, 3'b000, 1'b0, 1'b0);  // Unblocking, skid 50..52
    check("R6 unblocking entered", int'(stageState), 3);
    drive(3'b000, 3'b000, 8'h00, 3'b000, 3'b000, 1'b1, 1'b0);
    check("R7 unblock on squash", int'(upUnblock), 1);
    check("R7 no block on squash", int'(upBlock), 0);
    drive(3'b000, 3'b000, 8'h00, 3'b000, 3'b000, 1'b0, 1'b0);
    check("R7 skid flushed", int'(outValid), 0);
    check("R10 back to running", int'(stageState), 1);

    // R1 reset mid-stall clears the flags
    drive(3'b000, 3'b000, 8'h00, 3'b010, 3'b000, 1'b0, 1'b0);
    doReset();
    drive(3'b001, 3'b000, 8'h05, 3'b000, 3'b000, 1'b0, 1'b0);
    check("R1 flags cleared by reset", int'(outValid), 1);
    checkSlot("R1 post-reset pass", 0, 8'h05);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nErr);
    $finish;
  end

endmodule